// File: doc/BRIEF.md
# Bus-Switch Channel Select Register with Serial Target Port

This block is the digital core of a four-way downstream bus switch. It acts as a target on a two-wire serial bus (SCL/SDA). A host addresses it, writes one control byte that names a downstream channel, and can read that byte back. The read byte also carries the live interrupt state of all four channels. The block drives four one-hot channel enables that close the analog pass gates. A newly written selection is held back until the host ends the transfer with a STOP, so a channel is never joined to the upstream bus in the middle of a transfer.

SCL and SDA arrive as raw levels from the pads. They are sampled by a system clock that runs at least eight times faster than SCL. Three strap pins set the low address bits, so up to eight of these blocks can share one bus. The pads turn the single SDA output into an open-drain pull-down. The pass gates, level translation and clock stretching are outside this block.

Top module: `chan_sel_ctrl`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits equal binary 1110 followed by strap_pins[2:0] (MSB first, bit 0 = read/write with 1 = read). Any other address gets no acknowledge and leaves both the register and the channel enables unchanged.
- R2: After a matching write address, each following byte is acknowledged by pulling SDA low through the ninth clock. Its bits 2:0 are stored in the control register, and when several bytes are written the last complete byte wins.
- R3: The channel enables take a newly written value only after the next STOP. Until that STOP the previous enables stay in force.
- R4: During and after reset the control register is zero, all four channel enables are low and SDA is released.
- R5: Control bit 2 is the enable. When it is 0 no channel is enabled. When it is 1, bits 1:0 give the index n (0..3) and only chan_en[n] is high. At most one enable is ever high.
- R6: A read returns bits 7:4 = chan_irq[3:0] (bit 7 = channel 3, active high), bit 3 = 0 and bits 2:0 = the stored control bits. The interrupt bits are taken live when each byte starts.
- R7: During a read, an acknowledge from the host makes the block send another byte. A not-acknowledge ends the transfer and leaves SDA released.
- R8: Bits 7:3 of a written control byte have no effect.
- R9: A START seen at any point, including in the middle of a byte, releases SDA and restarts address matching. A partly received control byte is discarded.
- R10: A START or a STOP releases SDA. Outside of those conditions, the SDA output changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw serial clock level from the pad |
| sda_in | input | 1 | Raw serial data level from the pad |
| strap_pins | input | 3 | Low three bits of the target address |
| chan_irq | input | 4 | Live interrupt state per downstream channel, active high |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| chan_en | output | 4 | One-hot downstream channel enables |

## Verification
A pad edge passes through two synchroniser stages. The edge and condition detectors then act in the same cycle, and the control state registers one edge later. So sda_pull responds three clock edges after an SCL fall, and chan_en follows three edges after SDA rises for a STOP. The bench drives SDA a quarter period into SCL low, five clocks after the fall. It samples returned data in the middle of SCL high, and checks chan_en eight clocks after a STOP and again before it. Every sample and every input change happens on the falling system-clock edge, away from the edge where the design registers.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
    localparam int CH_NUM   = 4;
    localparam int SEL_W    = $clog2(CH_NUM);
    localparam int CTRL_W   = SEL_W + 1;
    localparam int STRAP_W  = 3;
    localparam int BYTE_W   = 8;
    localparam int PAD_W    = BYTE_W - CH_NUM - CTRL_W;
    localparam logic [6-STRAP_W:0] ADDR_FIXED = 4'b1110;

    typedef enum logic [2:0] {
        TG_IDLE,
        TG_ADDR,
        TG_ADDR_ACK,
        TG_WR,
        TG_WR_ACK,
        TG_RD,
        TG_RD_MACK,
        TG_RD_NEXT
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e        st;
        logic [BYTE_W-1:0] sh;
        logic [3:0]        cnt;
        logic              pull;
        logic              rd_dir;
    } tgt_regs_t;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CTRL_W-1:0] active;
    } ctrl_regs_t;
endpackage

// File: rtl/chsel_bus_sync.sv
module chsel_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_regs_t;

    sync_regs_t q, d;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_raw};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_raw};
        d.scl_prev = q.scl_pipe[STAGES-1];
        d.sda_prev = q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_lvl   = q.scl_pipe[STAGES-1];
    assign sda_lvl   = q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl && !q.scl_prev;
    assign scl_fall  = !scl_lvl && q.scl_prev;
    assign start_det = scl_lvl && q.scl_prev && q.sda_prev && !sda_lvl;
    assign stop_det  = scl_lvl && q.scl_prev && !q.sda_prev && sda_lvl;
endmodule

// File: rtl/chsel_target_fsm.sv
module chsel_target_fsm
    import chsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rd_byte,
    output logic               wr_stb,
    output logic [CTRL_W-1:0]  wr_sel,
    output logic               sda_pull
);
    tgt_regs_t q, d;
    logic [6:0] own_addr;

    assign own_addr = {ADDR_FIXED, strap};

    always_comb begin
        d      = q;
        wr_stb = 1'b0;
        wr_sel = '0;
        if (start_det) begin
            d.st   = TG_ADDR;
            d.cnt  = '0;
            d.pull = 1'b0;
        end else if (stop_det) begin
            d.st   = TG_IDLE;
            d.cnt  = '0;
            d.pull = 1'b0;
        end else begin
            unique case (q.st)
                TG_IDLE: ;
                TG_ADDR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_lvl};
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            if (d.sh[7:1] == own_addr) begin
                                d.st     = TG_ADDR_ACK;
                                d.rd_dir = sda_lvl;
                            end else begin
                                d.st = TG_IDLE;
                            end
                        end
                    end
                end
                TG_ADDR_ACK, TG_WR_ACK: begin
                    if (scl_fall) begin
                        if (!q.pull) begin
                            d.pull = 1'b1;
                        end else begin
                            d.pull = 1'b0;
                            d.cnt  = '0;
                            if (q.st == TG_ADDR_ACK && q.rd_dir) begin
                                d.st   = TG_RD;
                                d.pull = ~rd_byte[BYTE_W-1];
                                d.sh   = {rd_byte[BYTE_W-2:0], 1'b1};
                                d.cnt  = 4'd1;
                            end else begin
                                d.st = TG_WR;
                            end
                        end
                    end
                end
                TG_WR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_lvl};
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            wr_stb = 1'b1;
                            wr_sel = d.sh[CTRL_W-1:0];
                            d.st   = TG_WR_ACK;
                        end
                    end
                end
                TG_RD: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.pull = 1'b0;
                            d.st   = TG_RD_MACK;
                        end else begin
                            d.pull = ~q.sh[BYTE_W-1];
                            d.sh   = {q.sh[BYTE_W-2:0], 1'b1};
                            d.cnt  = q.cnt + 4'd1;
                        end
                    end
                end
                TG_RD_MACK: begin
                    if (scl_rise) begin
                        d.st = sda_lvl ? TG_IDLE : TG_RD_NEXT;
                    end
                end
                TG_RD_NEXT: begin
                    if (scl_fall) begin
                        d.st   = TG_RD;
                        d.pull = ~rd_byte[BYTE_W-1];
                        d.sh   = {rd_byte[BYTE_W-2:0], 1'b1};
                        d.cnt  = 4'd1;
                    end
                end
                default: d.st = TG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: TG_IDLE, sh: '0, cnt: '0, pull: 1'b0, rd_dir: 1'b0};
        else        q <= d;
    end

    assign sda_pull = q.pull;
endmodule

// File: rtl/chsel_ctrl_reg.sv
module chsel_ctrl_reg
    import chsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [CTRL_W-1:0] wr_sel,
    input  logic              stop_det,
    input  logic [CH_NUM-1:0] irq,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [CH_NUM-1:0] chan_en
);
    ctrl_regs_t q, d;

    always_comb begin
        d = q;
        if (wr_stb)   d.ctrl   = wr_sel;
        if (stop_det) d.active = q.ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_byte = {irq, {PAD_W{1'b0}}, q.ctrl};

    for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_dec
        assign chan_en[ch] = q.active[CTRL_W-1]
                          && (q.active[SEL_W-1:0] == SEL_W'(ch));
    end
endmodule

// File: rtl/chan_sel_ctrl.sv
module chan_sel_ctrl
    import chsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap_pins,
    input  logic [CH_NUM-1:0]  chan_irq,
    output logic               sda_pull,
    output logic [CH_NUM-1:0]  chan_en
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic wr_stb;
    logic [CTRL_W-1:0] wr_sel;
    logic [BYTE_W-1:0] rd_byte;

    chsel_bus_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    chsel_target_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .strap(strap_pins), .rd_byte(rd_byte), .wr_stb(wr_stb),
        .wr_sel(wr_sel), .sda_pull(sda_pull)
    );

    chsel_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel),
        .stop_det(stop_det), .irq(chan_irq), .rd_byte(rd_byte),
        .chan_en(chan_en)
    );
endmodule

// File: rtl/chan_sel_ctrl_chk.sv
module chan_sel_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_pull,
    input logic [3:0] chan_en
);
    AST_CHAN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_en)); // R5

    AST_SEL_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_en) |-> $past(stop_det)); // R3

    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull); // R9

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull); // R10

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det))
        |-> $stable(sda_pull)); // R10
endmodule

bind chan_sel_ctrl chan_sel_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_det(start_det),
    .stop_det(stop_det), .sda_pull(sda_pull), .chan_en(chan_en)
);

// File: tb/chan_sel_ctrl_tb_top.sv
module chan_sel_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 5;
    localparam logic [2:0] STRAP = 3'b101;

    typedef struct packed {
        logic [6:0] addr;
        logic [7:0] wb;
        logic [3:0] irq;
        logic       ack;
        logic [7:0] rd;
        logic [3:0] en;
    } vec_t;

    localparam logic [31:0] VECS [0:5] = '{
        {7'h75, 8'h04, 4'h0, 1'b1, 8'h04, 4'b0001},
        {7'h75, 8'hF7, 4'hA, 1'b1, 8'hA7, 4'b1000},
        {7'h75, 8'h05, 4'h5, 1'b1, 8'h55, 4'b0010},
        {7'h74, 8'h06, 4'h0, 1'b0, 8'h00, 4'b0010},
        {7'h75, 8'h03, 4'hF, 1'b1, 8'hF3, 4'b0000},
        {7'h75, 8'h06, 4'h1, 1'b1, 8'h16, 4'b0100}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [3:0] irq_in = 4'h0;
    logic sda_pull;
    logic [3:0] chan_en;
    logic sda_line;
    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_pull;
    always #(CLK_PERIOD/2) clk = ~clk;

    chan_sel_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .strap_pins(STRAP), .chan_irq(irq_in), .sda_pull(sda_pull),
        .chan_en(chan_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic rb);
        wait_clk(Q); sda_m = b;
        wait_clk(Q); scl_m = 1'b1;
        wait_clk(Q); rb = sda_line;
        wait_clk(Q); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(2*Q);
        sda_m = 1'b0; wait_clk(2*Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(Q); sda_m = 1'b0;
        wait_clk(Q); scl_m = 1'b1;
        wait_clk(2*Q); sda_m = 1'b1;
        wait_clk(2*Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        logic rb;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], rb);
        bus_bit(1'b1, rb);
        ack = ~rb;
    endtask

    task automatic read_byte(output logic [7:0] b, input logic send_ack);
        logic rb;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, rb);
            b[i] = rb;
        end
        bus_bit(~send_ack, rb);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic ack, ack2;
        logic [7:0] rb, rb2;
        logic [3:0] prev_en;
        vec_t v;

        wait_clk(3);
        check("R4 reset chan_en", 32'(chan_en), 32'h0);
        check("R4 reset sda_pull", 32'(sda_pull), 32'h0);
        rst_n = 1'b1;
        wait_clk(4);

        irq_in = 4'h9;
        bus_start();
        write_byte({7'h75, 1'b1}, ack);
        check("R1 read address ack", 32'(ack), 32'h1);
        read_byte(rb, 1'b0);
        check("R4 R6 read after reset", 32'(rb), 32'h90);
        bus_stop();

        prev_en = 4'h0;
        for (int i = 0; i < 6; i++) begin
            v = vec_t'(VECS[i]);
            irq_in = v.irq;
            bus_start();
            write_byte({v.addr, 1'b0}, ack);
            check("R1 write address ack", 32'(ack), 32'(v.ack));
            if (ack) begin
                write_byte(v.wb, ack2);
                check("R2 control byte ack", 32'(ack2), 32'h1);
                wait_clk(8);
                check("R3 enables held before STOP", 32'(chan_en), 32'(prev_en));
            end
            bus_stop();
            wait_clk(8);
            check("R3 R5 R8 enables after STOP", 32'(chan_en), 32'(v.en));
            check("R10 SDA released after STOP", 32'(sda_pull), 32'h0);
            bus_start();
            write_byte({v.addr, 1'b1}, ack);
            check("R1 read address ack", 32'(ack), 32'(v.ack));
            if (ack) begin
                read_byte(rb, 1'b0);
                wait_clk(Q);
                check("R7 SDA released after NACK", 32'(sda_pull), 32'h0);
                check("R6 R8 read byte", 32'(rb), 32'(v.rd));
            end
            bus_stop();
            prev_en = v.en;
        end

        bus_start();
        for (int i = 0; i < 4; i++) bus_bit(i != 3, rb[0]);
        bus_start();
        write_byte({7'h75, 1'b0}, ack);
        check("R9 address after restart", 32'(ack), 32'h1);
        write_byte(8'h07, ack2);
        bus_stop();
        wait_clk(8);
        check("R9 write after restart", 32'(chan_en), 32'b1000);

        bus_start();
        write_byte({7'h75, 1'b0}, ack);
        for (int i = 0; i < 4; i++) bus_bit(1'b0, rb[0]);
        bus_start();
        bus_stop();
        wait_clk(8);
        check("R9 partial byte discarded", 32'(chan_en), 32'b1000);

        irq_in = 4'h3;
        bus_start();
        write_byte({7'h75, 1'b1}, ack);
        read_byte(rb, 1'b1);
        irq_in = 4'hC;
        read_byte(rb2, 1'b0);
        bus_stop();
        check("R6 R9 first byte", 32'(rb), 32'h37);
        check("R6 R7 second byte live irq", 32'(rb2), 32'hC7);

        bus_start();
        write_byte({7'h75, 1'b0}, ack);
        write_byte(8'h04, ack2);
        write_byte(8'h05, ack2);
        check("R2 second byte ack", 32'(ack2), 32'h1);
        bus_stop();
        wait_clk(8);
        check("R2 last byte wins", 32'(chan_en), 32'b0010);

        rst_n = 1'b0;
        wait_clk(2);
        check("R4 reset clears enables", 32'(chan_en), 32'h0);
        rst_n = 1'b1;
        wait_clk(4);
        irq_in = 4'h0;
        bus_start();
        write_byte({7'h75, 1'b1}, ack);
        read_byte(rb, 1'b0);
        bus_stop();
        check("R4 register zero after reset", 32'(rb), 32'h00);

        finish_run();
    end
endmodule